// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns digitized supply-monitor flags and a push-button line into a clean processor reset. An external comparator reports whether the supply sits above its trip point. An active-low manual request line can also force a reset. Every asynchronous input is retimed by a two-flop synchronizer. A manual request must stay low for a minimum width before it counts. It then waits out a short assertion delay before reset takes effect.

Supply loss and a held manual request share one restartable hold-off counter. Reset is released only after every fault source has been clear for the whole selected timeout. The timeout is picked by a 2-bit select from four periods. A static strap chooses whether the reset pin is active-high or active-low. Low-line and power-fail warning flags are retimed and passed straight through, with no effect on the reset logic. All periods are given in microseconds and turned into clock counts from a clock-frequency parameter: count = floor(CLK_HZ * t_us / 1e6). Latencies below are in clock cycles, measured from an input change just before a rising edge.

Top module: `supv_reset_seq`

## Requirements
- R1: After reset and whenever the supply flag is low, reset is active. It is released only after the flag has been high without a break for T(sel) cycles, and the release appears between T and T+4 cycles after the flag rises.
- R2: When the supply flag falls, reset becomes active within 4 cycles, including during a running timeout. The timeout then restarts from its full length only once the flag is high again.
- R3: The select encodes 00 = T0 (1.4 ms), 01 = T1 (28 ms), 10 = T2 (200 ms), 11 = T3 (1600 ms). It is sampled only when a timeout count starts, so a later change has no effect on that count.
- R4: A manual low pulse shorter than Q cycles (Q from 25 us) is ignored: reset stays released and the state returns to run.
- R5: A manual request held low asserts reset no earlier than Q+D and no later than Q+D+4 cycles after the line falls, where D comes from the 12 us delay.
- R6: Reset stays active while the manual line is held low. It releases T cycles (up to T+4) after the line goes high. If the supply is also low, the timeout starts only after the last source clears.
- R7: With the polarity strap at 1 the reset pin is high when active. With the strap at 0 it is the exact inverse, following a strap change within one cycle. During the block reset, the pin shows the active level.
- R8: The low-line and power-fail outputs copy their inputs with a 3-cycle latency, and they never change reset timing.
- R9: The debug state reads 0 = hold, 1 = qualify manual, 2 = manual delay, 3 = timeout, 4 = run, and never any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_ok_i | input | 1 | Supply above threshold flag, asynchronous |
| mr_n_i | input | 1 | Manual reset request, active-low, asynchronous |
| tsel_i | input | 2 | Timeout period select |
| pol_hi_i | input | 1 | Static polarity strap, 1 = active-high reset pin |
| lowline_i | input | 1 | Low-line warning flag, asynchronous |
| pwrfail_i | input | 1 | Power-fail warning flag, asynchronous |
| rst_o | output | 1 | Processor reset in the strapped polarity |
| lowline_o | output | 1 | Retimed low-line warning |
| pwrfail_o | output | 1 | Retimed power-fail warning |
| dbg_state_o | output | 3 | Sequencer state code |

## Verification
The supply flag is dropped and raised in three situations: from run, in the middle of a timeout, and while a manual request is held. These show whether the counter restarts, and whether the release waits for the last source to clear. The manual line is driven with a pulse just under the qualifying width, a sustained press, and a press that overlaps supply loss. These separate the width filter from the assertion delay and from the hold behaviour. Each of the four select codes is timed on its own. The select is also changed in the middle of a count, which shows that it is sampled only at the start. Warning flags and the polarity strap are toggled during run and during timeout to confirm that they leave reset timing unchanged.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_QUAL  = 3'd1,
    ST_DELAY = 3'd2,
    ST_TMO   = 3'd3,
    ST_RUN   = 3'd4
  } supv_st_e;

  function automatic logic [63:0] us_to_cyc(input logic [63:0] hz, input logic [63:0] us);
    return (hz * us) / 64'd1_000_000;
  endfunction

  function automatic logic [63:0] max4(input logic [63:0] a, input logic [63:0] b,
                                       input logic [63:0] c, input logic [63:0] d);
    logic [63:0] m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/supv_mr_qual.sv
module supv_mr_qual #(
  parameter int unsigned QUAL = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic mr_low_i,
  output logic held_o
);

  localparam int unsigned QW = $clog2(QUAL + 1);

  logic [QW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)                      run_q <= '0;
    else if (!mr_low_i)           run_q <= '0;
    else if (run_q != QW'(QUAL))  run_q <= run_q + 1'b1;
  end

  assign held_o = (run_q == QW'(QUAL));

endmodule

// File: rtl/supv_timer.sv
module supv_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
  import supv_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned MR_MIN_US   = 25,
  parameter int unsigned MR_DLY_US   = 12,
  parameter int unsigned TMO0_US     = 1_400,
  parameter int unsigned TMO1_US     = 28_000,
  parameter int unsigned TMO2_US     = 200_000,
  parameter int unsigned TMO3_US     = 1_600_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok_i,
  input  logic       mr_n_i,
  input  logic [1:0] tsel_i,
  input  logic       pol_hi_i,
  input  logic       lowline_i,
  input  logic       pwrfail_i,
  output logic       rst_o,
  output logic       lowline_o,
  output logic       pwrfail_o,
  output logic [2:0] dbg_state_o
);

  localparam logic [63:0] QUAL_CYC = us_to_cyc(64'(CLK_HZ), 64'(MR_MIN_US));
  localparam logic [63:0] DLY_CYC  = us_to_cyc(64'(CLK_HZ), 64'(MR_DLY_US));
  localparam logic [63:0] TMO_CYC [4] = '{
    us_to_cyc(64'(CLK_HZ), 64'(TMO0_US)),
    us_to_cyc(64'(CLK_HZ), 64'(TMO1_US)),
    us_to_cyc(64'(CLK_HZ), 64'(TMO2_US)),
    us_to_cyc(64'(CLK_HZ), 64'(TMO3_US))
  };
  localparam logic [63:0] MAX_CYC = max4(TMO_CYC[0], TMO_CYC[1], TMO_CYC[2],
                                          (TMO_CYC[3] > DLY_CYC) ? TMO_CYC[3] : DLY_CYC);
  localparam int unsigned CW     = $clog2(MAX_CYC + 64'd1);
  localparam int unsigned QUAL_I = int'(QUAL_CYC);

  // retimed inputs: {supply, manual_n, lowline, pwrfail}
  logic [3:0] sync_w;
  logic       s_ok, s_mrn, s_ll, s_pf;

  supv_sync #(
    .W      (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({supply_ok_i, mr_n_i, lowline_i, pwrfail_i}),
    .q_o (sync_w)
  );

  assign {s_ok, s_mrn, s_ll, s_pf} = sync_w;

  logic mr_held;

  supv_mr_qual #(.QUAL(QUAL_I)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .mr_low_i(!s_mrn),
    .held_o  (mr_held)
  );

  supv_st_e state_q, state_d;
  logic          tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_HOLD:  if (s_ok && s_mrn)        state_d = ST_TMO;
      ST_TMO:   if (!s_ok || mr_held)     state_d = ST_HOLD;
                else if (tmr_zero)        state_d = ST_RUN;
      ST_RUN:   if (!s_ok)                state_d = ST_HOLD;
                else if (!s_mrn)          state_d = ST_QUAL;
      ST_QUAL:  if (!s_ok)                state_d = ST_HOLD;
                else if (mr_held)         state_d = ST_DELAY;
                else if (s_mrn)           state_d = ST_RUN;
      ST_DELAY: if (!s_ok || tmr_zero)    state_d = ST_HOLD;
      default:                            state_d = ST_HOLD;
    endcase
  end

  // one counter serves both the manual delay and the hold-off timeout
  assign tmr_load = (state_d != state_q) && ((state_d == ST_TMO) || (state_d == ST_DELAY));
  assign tmr_val  = (state_d == ST_TMO) ? CW'(TMO_CYC[tsel_i] - 64'd1)
                                        : CW'(DLY_CYC - 64'd1);

  supv_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tmr_zero)
  );

  logic act_d, act_q, rst_pin_q, ll_q, pf_q;

  assign act_d = (state_d == ST_HOLD) || (state_d == ST_TMO);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_HOLD;
      act_q     <= 1'b1;
      rst_pin_q <= pol_hi_i;
      ll_q      <= 1'b0;
      pf_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      act_q     <= act_d;
      rst_pin_q <= pol_hi_i ? act_d : ~act_d;
      ll_q      <= s_ll;
      pf_q      <= s_pf;
    end
  end

  assign rst_o       = rst_pin_q;
  assign lowline_o   = ll_q;
  assign pwrfail_o   = pf_q;
  assign dbg_state_o = state_q;

endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk
  import supv_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        supply_ok_i,
  input logic        mr_n_i,
  input logic        lowline_i,
  input logic        lowline_o,
  input logic        pwrfail_i,
  input logic        pwrfail_o,
  input logic        act,
  input logic [2:0]  st,
  input logic [31:0] qual_lim
);

  logic [1:0]  age_q;
  logic [31:0] lowrun_q;

  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst || mr_n_i)                  lowrun_q <= '0;
    else if (lowrun_q != 32'hFFFF_FFFF) lowrun_q <= lowrun_q + 32'd1;
  end

  AST_LOSS_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3 && !$past(supply_ok_i, 2) && !$past(supply_ok_i, 1)) |=> act); // R2

  AST_RELEASE_AFTER_TMO: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && $past(st) != ST_RUN && $past(st) != ST_QUAL) |-> $past(st) == ST_TMO); // R1

  AST_MR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DELAY && $past(st) != ST_DELAY) |-> $past(lowrun_q, 2) >= qual_lim); // R4

  AST_LOWLINE_PASS: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3) |-> lowline_o == $past(lowline_i, 3)); // R8

  AST_PWRFAIL_PASS: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3) |-> pwrfail_o == $past(pwrfail_i, 3)); // R8

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    st <= 3'd4); // R9

endmodule

bind supv_reset_seq supv_reset_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .supply_ok_i(supply_ok_i),
  .mr_n_i     (mr_n_i),
  .lowline_i  (lowline_i),
  .lowline_o  (lowline_o),
  .pwrfail_i  (pwrfail_i),
  .pwrfail_o  (pwrfail_o),
  .act        (act_q),
  .st         (state_q),
  .qual_lim   (QUAL_I)
);

// File: tb/supv_reset_seq_tb.sv
`timescale 1ns/1ps
module supv_reset_seq_tb;

  localparam int Q  = 25;
  localparam int D  = 12;
  localparam int T0 = 40;
  localparam int T1 = 80;
  localparam int T2 = 160;
  localparam int T3 = 320;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ok = 1'b1, mrn = 1'b1, pol = 1'b1, ll = 1'b0, pf = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       rst_o, ll_o, pf_o;
  logic [2:0] st_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  supv_reset_seq #(
    .CLK_HZ(1_000_000), .MR_MIN_US(Q), .MR_DLY_US(D),
    .TMO0_US(T0), .TMO1_US(T1), .TMO2_US(T2), .TMO3_US(T3), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .supply_ok_i(ok), .mr_n_i(mrn), .tsel_i(sel),
    .pol_hi_i(pol), .lowline_i(ll), .pwrfail_i(pf),
    .rst_o(rst_o), .lowline_o(ll_o), .pwrfail_o(pf_o), .dbg_state_o(st_o)
  );

  typedef struct packed {
    logic       ok;
    logic       mrn;
    logic       pol;
    logic       ll;
    logic       pf;
    logic [7:0] wt;
    logic       e_rst;
    logic       e_ll;
    logic       e_pf;
    logic [2:0] e_st;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd60, 1'b0, 1'b0, 1'b0, 3'd4}, // R1 release after T0
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3,  1'b1, 1'b0, 1'b0, 3'd4}, // R7 inverse form
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd5,  1'b1, 1'b1, 1'b0, 3'd4}, // R8 low-line
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd5,  1'b1, 1'b0, 1'b1, 3'd4}, // R8 power-fail
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd5,  1'b1, 1'b0, 1'b0, 3'd0}, // R2 supply loss
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd10, 1'b1, 1'b0, 1'b0, 3'd3}, // R1 counting
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd40, 1'b0, 1'b0, 1'b0, 3'd4}, // R1 released
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd10, 1'b0, 1'b0, 1'b0, 3'd1}, // R9 qualify
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd40, 1'b1, 1'b0, 1'b0, 3'd0}, // R5 asserted
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd10, 1'b1, 1'b0, 1'b0, 3'd3}, // R6 timeout
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd50, 1'b0, 1'b0, 1'b0, 3'd4}, // R6 released
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd30, 1'b0, 1'b0, 1'b0, 3'd2}, // R9 delay state
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd15, 1'b1, 1'b0, 1'b0, 3'd0}, // R5 hold
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd60, 1'b0, 1'b0, 1'b0, 3'd4}, // R6 released
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd60, 1'b0, 1'b1, 1'b1, 3'd4}  // R8 no effect on run
  };

  function automatic logic active();
    return pol ? rst_o : ~rst_o;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas(input logic want, input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (active() == want) break;
    end
  endtask

  task automatic run_timeout(input logic [1:0] s, input int t, input string req);
    int n;
    ok = 1'b0;
    cyc(5);
    sel = s;
    ok = 1'b1;
    meas(1'b0, t + 20, n);
    check_rng(req, n, t, t + 4);
  endtask

  initial begin
    #(5.0 * 150_000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    int bad;
    cyc(5);
    check("R7 reset pin active during block reset", rst_o, 1);
    check("R9 reset state hold", st_o, 0);
    check("R8 low-line clear in reset", ll_o, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      ok = VECS[i].ok; mrn = VECS[i].mrn; pol = VECS[i].pol;
      ll = VECS[i].ll; pf = VECS[i].pf;
      cyc(int'(VECS[i].wt));
      check($sformatf("R1/R9 vec%0d rst_o", i), rst_o, VECS[i].e_rst);
      check($sformatf("R8 vec%0d low-line", i), ll_o, VECS[i].e_ll);
      check($sformatf("R8 vec%0d power-fail", i), pf_o, VECS[i].e_pf);
      check($sformatf("R9 vec%0d state", i), st_o, VECS[i].e_st);
    end
    ll = 1'b0; pf = 1'b0; pol = 1'b1;
    cyc(5);

    // R3 each select code
    run_timeout(2'd0, T0, "R3 sel 00");
    run_timeout(2'd1, T1, "R3 sel 01");
    run_timeout(2'd2, T2, "R3 sel 10");
    run_timeout(2'd3, T3, "R3 sel 11");

    // R3 select sampled at start only
    ok = 1'b0; cyc(5); sel = 2'd1; ok = 1'b1;
    cyc(10); sel = 2'd0;
    meas(1'b0, T1 + 20, n);
    check_rng("R3 select change mid-count", n + 10, T1, T1 + 4);

    // R2 drop during timeout restarts the count
    ok = 1'b0; cyc(5); ok = 1'b1; cyc(20);
    ok = 1'b0; cyc(4);
    check("R2 hold after drop in timeout", st_o, 0);
    ok = 1'b1;
    meas(1'b0, T0 + 20, n);
    check_rng("R2 restart full timeout", n, T0, T0 + 4);

    // R2 drop from run
    cyc(5);
    ok = 1'b0;
    meas(1'b1, 20, n);
    check_rng("R2 assert latency", n, 1, 4);
    ok = 1'b1;
    meas(1'b0, T0 + 20, n);

    // R4 short manual pulse ignored
    cyc(5);
    mrn = 1'b0; cyc(Q - 3); mrn = 1'b1;
    bad = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (active()) bad++;
    end
    check("R4 short pulse no reset", bad, 0);
    check("R4 back in run", st_o, 4);

    // R5 qualified request latency
    mrn = 1'b0;
    meas(1'b1, Q + D + 20, n);
    check_rng("R5 manual assert latency", n, Q + D, Q + D + 4);

    // R6 held low keeps reset, release one timeout later
    bad = 0;
    for (int k = 0; k < 3 * T0; k++) begin
      @(negedge clk);
      if (!active()) bad++;
    end
    check("R6 held while manual low", bad, 0);
    mrn = 1'b1;
    meas(1'b0, T0 + 20, n);
    check_rng("R6 release after manual high", n, T0, T0 + 4);

    // R6 both sources: timeout waits for the last to clear
    cyc(5);
    ok = 1'b0; mrn = 1'b0; cyc(50);
    ok = 1'b1;
    bad = 0;
    for (int k = 0; k < 3 * T0; k++) begin
      @(negedge clk);
      if (!active()) bad++;
    end
    check("R6 held until last source clears", bad, 0);
    mrn = 1'b1;
    meas(1'b0, T0 + 20, n);
    check_rng("R6 release after last source", n, T0, T0 + 4);

    // R8 warnings during timeout do not disturb it
    cyc(5);
    ok = 1'b0; cyc(5);
    ok = 1'b1; ll = 1'b1; pf = 1'b1;
    meas(1'b0, T0 + 20, n);
    check_rng("R8 timeout unaffected by warnings", n, T0, T0 + 4);
    check("R8 low-line follows", ll_o, 1);
    ll = 1'b0;
    cyc(3);
    check("R8 low-line 3-cycle latency", ll_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule